// File: doc/BRIEF.md
# Registered Eight-Bit Opcode ALU

This block is a small clocked arithmetic and logic unit. On each rising clock edge it takes two unsigned operands and a four-bit operation code, applies the selected operation, and stores the result in an output register. The result therefore appears exactly one clock after its operands and code were presented. There are no carry or status outputs, and sums simply wrap.

The operation set holds ten codes. They cover a pass of the first operand, two kinds of addition, three bitwise logic functions, a complement, two one-bit logical shifts and an explicit clear. The six remaining codes also clear the result. An active-high reset, sampled on the clock edge, forces the result to zero ahead of any operation.

Top module: `opalu8`

## Requirements
- R1: The output register updates on every rising clock edge, and a result appears exactly one cycle after the edge at which its operands and code were sampled.
- R2: When `rst` is high at a rising edge, `y` becomes 0x00 at that edge whatever the operands and code are.
- R3: Code 4'b0000 loads operand `a` unchanged.
- R4: Code 4'b0001 loads `a + b` modulo 256, and the carry is discarded.
- R5: Code 4'b0010 loads `a` plus the bitwise inverse of `b` modulo 256, with no added one.
- R6: Codes 4'b0011, 4'b0100 and 4'b0101 load `a & b`, `a | b` and `a ^ b` respectively.
- R7: Code 4'b0110 loads the bitwise inverse of `a`.
- R8: Code 4'b0111 loads `a` shifted left by one bit. Bit 0 is filled with zero and bit 7 of `a` is dropped.
- R9: Code 4'b1000 loads `a` shifted right by one bit. Bit 7 is filled with zero and bit 0 of `a` is dropped.
- R10: Code 4'b1001 loads 0x00.
- R11: Codes 4'b1010 through 4'b1111 load 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Active-high reset, sampled on the clock edge, clears the result |
| a | input | 8 | First unsigned operand |
| b | input | 8 | Second unsigned operand |
| sel | input | 4 | Operation code |
| y | output | 8 | Registered result |

## Verification
The only state is the result register, so a wrong internal value shows up on `y` at the very next edge and is overwritten one edge later. Faults therefore show as single-cycle mismatches tied to the code and operands of the previous cycle. For this reason the bench issues a new operation on every cycle and compares each result against the inputs from exactly one edge earlier. Operands such as 0x00, 0xFF, 0x80 and 0x01 show wrong shift fill, a stray +1 in the inverted add, and a carry that leaks into the result.

// File: rtl/opalu8_pkg.sv
package opalu8_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_PASS   = 4'd0,
    OPC_ADD    = 4'd1,
    OPC_ADDINV = 4'd2,
    OPC_AND    = 4'd3,
    OPC_OR     = 4'd4,
    OPC_XOR    = 4'd5,
    OPC_INV    = 4'd6,
    OPC_SHL    = 4'd7,
    OPC_SHR    = 4'd8,
    OPC_CLR    = 4'd9
  } opc_e;

endpackage

// File: rtl/opalu8_arith.sv
module opalu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] sum_inv
);

  logic [W-1:0] b_inv;

  always_comb begin
    b_inv   = ~b;
    sum     = a + b;
    sum_inv = a + b_inv;
  end

endmodule

// File: rtl/opalu8_logic.sv
module opalu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] inv_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = a[i] & b[i];
    assign or_o[i]  = a[i] | b[i];
    assign xor_o[i] = a[i] ^ b[i];
    assign inv_o[i] = ~a[i];
  end

endmodule

// File: rtl/opalu8_shift.sv
module opalu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] shl,
  output logic [W-1:0] shr
);

  assign shl[0]   = 1'b0;
  assign shr[W-1] = 1'b0;

  for (genvar i = 1; i < W; i++) begin : g_lane
    assign shl[i]   = a[i-1];
    assign shr[i-1] = a[i];
  end

endmodule

// File: rtl/opalu8.sv
module opalu8
  import opalu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [OPC_W-1:0] sel,
  output logic [W-1:0]     y
);

  logic [W-1:0] sum, sum_inv;
  logic [W-1:0] and_v, or_v, xor_v, inv_v;
  logic [W-1:0] shl_v, shr_v;
  logic [W-1:0] y_d, y_q;

  opalu8_arith #(.W(W)) u_arith (
    .a       (a),
    .b       (b),
    .sum     (sum),
    .sum_inv (sum_inv)
  );

  opalu8_logic #(.W(W)) u_logic (
    .a     (a),
    .b     (b),
    .and_o (and_v),
    .or_o  (or_v),
    .xor_o (xor_v),
    .inv_o (inv_v)
  );

  opalu8_shift #(.W(W)) u_shift (
    .a   (a),
    .shl (shl_v),
    .shr (shr_v)
  );

  // next-state selection
  always_comb begin
    case (sel)
      OPC_PASS:   y_d = a;
      OPC_ADD:    y_d = sum;
      OPC_ADDINV: y_d = sum_inv;
      OPC_AND:    y_d = and_v;
      OPC_OR:     y_d = or_v;
      OPC_XOR:    y_d = xor_v;
      OPC_INV:    y_d = inv_v;
      OPC_SHL:    y_d = shl_v;
      OPC_SHR:    y_d = shr_v;
      default:    y_d = '0;
    endcase
  end

  // result register, synchronous active-high clear
  always_ff @(posedge clk) begin
    if (rst) y_q <= '0;
    else     y_q <= y_d;
  end

  assign y = y_q;

endmodule

// File: rtl/opalu8_chk.sv
module opalu8_chk
  import opalu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     a,
  input logic [W-1:0]     b,
  input logic [OPC_W-1:0] sel,
  input logic [W-1:0]     y
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R2
  assert_reset_clears_R2: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    rst |=> (y == '0));

  // R1 / R3
  assert_pass_R3: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_PASS) |=> (y == $past(a)));

  assert_add_wrap_R4: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_ADD) |=> (y == $past(a) + $past(b)));

  assert_add_inv_R5: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_ADDINV) |=> (y == $past(a) + ~$past(b)));

  assert_and_R6: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_AND) |=> (y == ($past(a) & $past(b))));

  assert_or_R6: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_OR) |=> (y == ($past(a) | $past(b))));

  assert_xor_R6: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_XOR) |=> (y == ($past(a) ^ $past(b))));

  assert_inv_R7: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_INV) |=> (y == ~$past(a)));

  assert_shl_R8: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_SHL) |=> (y[0] == 1'b0 && y[W-1:1] == $past(a[W-2:0])));

  assert_shr_R9: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_SHR) |=> (y[W-1] == 1'b0 && y[W-2:0] == $past(a[W-1:1])));

  assert_clr_R10: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel == OPC_CLR) |=> (y == '0));

  assert_unused_R11: assert property (@(posedge clk) disable iff (armed !== 1'b1)
    (!rst && sel > OPC_CLR) |=> (y == '0));

endmodule

bind opalu8 opalu8_chk #(.W(W)) u_chk (
  .clk (clk),
  .rst (rst),
  .a   (a),
  .b   (b),
  .sel (sel),
  .y   (y)
);

// File: tb/sim_opalu8.sv
module sim_opalu8;

  logic       clk;
  logic       rst;
  logic [7:0] a, b;
  logic [3:0] sel;
  logic [7:0] y;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  logic [7:0] exp_q;
  string      tag_q;
  bit         pend = 0;

  opalu8 u0 (.clk(clk), .rst(rst), .a(a), .b(b), .sel(sel), .y(y));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] ref_y(input logic [7:0] ra, input logic [7:0] rb,
                                       input logic [3:0] rs, input logic rr);
    if (rr) return 8'h00;
    case (rs)
      4'd0: return ra;
      4'd1: return 8'((ra + rb) & 9'h0FF);
      4'd2: return 8'((ra + (8'hFF - rb)) & 9'h0FF);
      4'd3: return ra & rb;
      4'd4: return ra | rb;
      4'd5: return ra ^ rb;
      4'd6: return 8'hFF - ra;
      4'd7: return {ra[6:0], 1'b0};
      4'd8: return {1'b0, ra[7:1]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] rs, input logic rr);
    if (rr) return "R2";
    case (rs)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4, 4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  // One operation per cycle (R1): check the result of the previous edge,
  // then present the next operation.
  task automatic step(input logic [7:0] ta, input logic [7:0] tb,
                      input logic [3:0] ts, input logic tr);
    @(negedge clk);
    if (pend) begin
      compared++;
      if (y !== exp_q) begin
        mismatched++;
        $display("FAIL %s (R1 one-cycle result): y=%02h expected=%02h", tag_q, y, exp_q);
      end
    end
    a = ta; b = tb; sel = ts; rst = tr;
    exp_q = ref_y(ta, tb, ts, tr);
    tag_q = req_of(ts, tr);
    pend  = 1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] corners [4];
    corners[0] = 8'h00; corners[1] = 8'hFF; corners[2] = 8'h80; corners[3] = 8'h01;
    a = '0; b = '0; sel = '0; rst = 1'b1;
    void'($urandom(32'h1234_5EED));

    // reset state: R2
    step(8'h00, 8'h00, 4'd0, 1'b1);
    step(8'h00, 8'h00, 4'd0, 1'b1);
    // reset priority over an active code: R2
    step(8'hFF, 8'h01, 4'd1, 1'b1);
    step(8'hA5, 8'h5A, 4'd6, 1'b1);

    // directed corners over every code, R3..R11
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          step(corners[i], corners[j], 4'(s), 1'b0);

    // specific boundaries
    step(8'hFF, 8'h01, 4'd1, 1'b0); // R4 wrap to 0x00
    step(8'h80, 8'h80, 4'd1, 1'b0); // R4 carry dropped
    step(8'h05, 8'h05, 4'd2, 1'b0); // R5 gives 0xFF, no +1
    step(8'h81, 8'h00, 4'd7, 1'b0); // R8 -> 0x02
    step(8'h81, 8'h00, 4'd8, 1'b0); // R9 -> 0x40
    step(8'h00, 8'h00, 4'd0, 1'b1); // R2 mid-stream
    step(8'h3C, 8'hC3, 4'd0, 1'b0); // R3 after reset

    // constrained random: mostly valid codes, some unused, rare reset
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] rs;
      logic       rr;
      rs = ($urandom % 8 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
      rr = ($urandom % 50 == 0);
      step(8'($urandom), 8'($urandom), rs, rr);
    end
    step(8'h00, 8'h00, 4'd0, 1'b0); // flush last pending compare

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule